// File: doc/BRIEF.md
# Host Register Window for a Message-Link Adapter Card

This block sits between an 8-bit I/O host bus and the inside of an adapter card. It is an eight-byte register window. The host uses it to set up interrupt routing and signalling mode, to insert a wait state, and to hold the on-card processor in reset. It also uses it to pass single bytes to and from an internal message link and to drive the pins of a serial EEPROM directly. A read-only interrupt source register shows which sources are pending. One bit of that register carries a 16-bit card signature that the host can read one bit at a time after reset.

Both link directions are valid/ready streams that carry one byte each. The inbound byte is accepted only while the inbound holding register is empty: `link_in_ready` is low from acceptance until the host reads the data-input register, so a sender must hold `link_in_valid` and `link_in_data` stable until it sees ready. The outbound byte is offered with `link_out_valid` from the host's write until the cycle in which `link_out_ready` is seen high. While the byte is offered, `link_out_data` does not change. The combined interrupt request is routed to one of seven interrupt lines, or to none. It is signalled either as a level or as a fixed-length pulse.

Host accesses are single-cycle strobes. Read data is combinational from the address. Side effects of an access take effect at the clock edge on which the strobe is high.

Top module: `isa_host_window`

## Requirements
- R1: After reset the configuration register (offset 0) reads 0x38, the output status register (offset 7) reads 0x01, the input status register (offset 6) reads 0x00, `link_in_ready` is 1, `link_out_valid` is 0, and no interrupt line is driven.
- R2: The configuration register keeps bits 7:3 and 1:0 as written, and bit 2 always reads 0. `cpu_reset` follows bit 7. `host_wait` is high during any read or write strobe while bit 1 is set, and low otherwise.
- R3: The routing field, configuration bits 5:3, selects the driven line: code k from 0 to 6 drives `irq_lines[k]`, standing for interrupt numbers 15, 12, 11, 10, 3, 5, 7 in that order. Code 7 drives no line. At most one line is ever high.
- R4: With configuration bit 6 clear (level mode), the selected line equals the combined request. The request is the OR of three terms: input-ready with its enable, output-ready with its enable, and the registered error input with configuration bit 0.
- R5: With bit 6 set (pulse mode), a rising edge of the combined request drives the selected line for exactly 4 cycles, starting one clock after the rise. A rise that occurs while a pulse is running does not extend it.
- R6: Interrupt source register (offset 1) layout: bit 0 = error input AND configuration bit 0; bit 1 = output-ready AND output enable; bit 2 = input-ready AND input enable; bit 3 = signature bit; bit 4 = the error input, registered once. Bits 7:5 read 0.
- R7: Bit 3 of offset 1 presents the signature 0x0201, least significant bit first. Each read of offset 1 advances one bit. After 16 reads the bit stays 0 until the pointer is restarted.
- R8: While configuration bit 7 is set, the signature pointer is held at its first bit.
- R9: The EEPROM register (offset 2) drives `ee_di`, `ee_clk`, `ee_cs` and `ee_hold` from written bits 1, 2, 3 and 4. It reads back `ee_do` in bit 0, the four pin bits in bits 4:1, and 0 in bits 7:5.
- R10: An inbound byte accepted from the link is read at offset 4 and sets input-ready (offset 6 bit 0). A read of offset 4 clears input-ready and raises `link_in_ready` on the next cycle. Bit 1 of offset 6 is the input interrupt enable.
- R11: A write to offset 5 while output-ready (offset 7 bit 0) is set clears output-ready and offers the byte on the link. A write while output-ready is clear is ignored. A link transfer sets output-ready again. Bit 1 of offset 7 is the output interrupt enable.
- R12: Offsets 3 and 5 read 0, and a write to offset 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Register offset |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wr | input | 1 | Write strobe, one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for `host_addr` |
| host_wait | output | 1 | Wait-state request during an access |
| irq_lines | output | 7 | Routed interrupt lines |
| cpu_reset | output | 1 | Soft reset to the internal processor |
| err_in | input | 1 | Error signal from the internal processor |
| ee_do | input | 1 | EEPROM serial data out |
| ee_di | output | 1 | EEPROM serial data in |
| ee_clk | output | 1 | EEPROM clock |
| ee_cs | output | 1 | EEPROM chip select |
| ee_hold | output | 1 | EEPROM hold |
| link_in_valid | input | 1 | Inbound byte valid |
| link_in_data | input | 8 | Inbound byte |
| link_in_ready | output | 1 | Inbound holding register empty |
| link_out_valid | output | 1 | Outbound byte offered |
| link_out_data | output | 8 | Outbound byte |
| link_out_ready | input | 1 | Link takes the outbound byte |

## Verification
The bench builds the block with its default parameters: a 16-bit signature of value 0x0201 and a 4-cycle pulse. With a 16-bit signature, sixteen reads walk the whole pattern and a seventeenth read reaches the exhausted state. The 4-cycle pulse is short enough to count the whole pulse with margin in a fixed window. Routing is swept over all eight codes while a request is held active. This covers the silent code and the one-line-at-most rule.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;

  localparam logic [2:0] OFS_CFG   = 3'd0;
  localparam logic [2:0] OFS_ISR   = 3'd1;
  localparam logic [2:0] OFS_EEP   = 3'd2;
  localparam logic [2:0] OFS_EEN   = 3'd3;
  localparam logic [2:0] OFS_DIN   = 3'd4;
  localparam logic [2:0] OFS_DOUT  = 3'd5;
  localparam logic [2:0] OFS_ISTAT = 3'd6;
  localparam logic [2:0] OFS_OSTAT = 3'd7;

  localparam logic [SEL_W-1:0] LINE_NONE = '1;

  typedef struct packed {
    logic             srst;
    logic             pulse;
    logic [SEL_W-1:0] line;
    logic             rsvd;
    logic             wait_en;
    logic             perr_en;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{srst: 1'b0, pulse: 1'b0, line: LINE_NONE,
                                 rsvd: 1'b0, wait_en: 1'b0, perr_en: 1'b0};
endpackage

// File: rtl/isa_win_sigid.sv
module isa_win_sigid #(
  parameter int          SIG_W   = 16,
  parameter logic [15:0] SIG_VAL = 16'h0201
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic advance,
  output logic bit_o
);
  localparam int PW = $clog2(SIG_W + 1);
  localparam int IW = $clog2(SIG_W);
  localparam logic [PW-1:0] LAST = PW'(SIG_W);

  logic [PW-1:0]    ptr;
  logic [SIG_W-1:0] pattern;

  assign pattern = SIG_VAL[SIG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      ptr <= '0;
    else if (restart)                ptr <= '0;
    else if (advance && ptr != LAST) ptr <= ptr + 1'b1;
  end

  assign bit_o = (ptr != LAST) ? pattern[ptr[IW-1:0]] : 1'b0;
endmodule

// File: rtl/isa_win_link.sv
module isa_win_link #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          host_take,
  output logic          in_full,
  output logic [DW-1:0] in_byte,
  input  logic          host_put,
  input  logic [DW-1:0] host_byte,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready,
  output logic          out_free
);
  assign in_ready  = !in_full;
  assign out_valid = !out_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_full <= 1'b0;
      in_byte <= '0;
    end else if (in_valid && in_ready) begin
      in_full <= 1'b1;
      in_byte <= in_data;
    end else if (host_take) begin
      in_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_free <= 1'b1;
      out_data <= '0;
    end else if (host_put && out_free) begin
      out_free <= 1'b0;
      out_data <= host_byte;
    end else if (out_valid && out_ready) begin
      out_free <= 1'b1;
    end
  end
endmodule

// File: rtl/isa_win_irq.sv
module isa_win_irq #(
  parameter int SEL_W     = 3,
  parameter int PULSE_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic                 pulse_mode,
  input  logic [SEL_W-1:0]     sel,
  output logic [2**SEL_W-2:0]  lines
);
  localparam int NL = 2**SEL_W - 1;
  localparam int CW = $clog2(PULSE_LEN + 1);

  logic          req_q;
  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      cnt   <= '0;
    end else begin
      req_q <= req;
      if (req && !req_q && cnt == '0) cnt <= CW'(PULSE_LEN);
      else if (cnt != '0)             cnt <= cnt - 1'b1;
    end
  end

  assign active = pulse_mode ? (cnt != '0) : req;

  for (genvar i = 0; i < NL; i++) begin : g_line
    assign lines[i] = active && (sel == SEL_W'(i));
  end
endmodule

// File: rtl/isa_host_window.sv
module isa_host_window
  import isa_win_pkg::*;
#(
  parameter int          SIG_WIDTH = 16,
  parameter logic [15:0] SIG_VALUE = 16'h0201,
  parameter int          PULSE_LEN = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  host_addr,
  input  logic        host_rd,
  input  logic        host_wr,
  input  logic [7:0]  host_wdata,
  output logic [7:0]  host_rdata,
  output logic        host_wait,
  output logic [6:0]  irq_lines,
  output logic        cpu_reset,
  input  logic        err_in,
  input  logic        ee_do,
  output logic        ee_di,
  output logic        ee_clk,
  output logic        ee_cs,
  output logic        ee_hold,
  input  logic        link_in_valid,
  input  logic [7:0]  link_in_data,
  output logic        link_in_ready,
  output logic        link_out_valid,
  output logic [7:0]  link_out_data,
  input  logic        link_out_ready
);
  cfg_t       cfg_q;
  logic [3:0] eep_q;
  logic       in_ie, out_ie, err_q;
  logic       in_full, out_free, sig_bit;
  logic [7:0] in_byte;
  logic       wr_cfg, wr_eep, wr_ist, wr_ost, wr_dout, rd_din, rd_isr;
  logic       err_int, in_int, out_int, irq_req;

  assign wr_cfg  = host_wr && host_addr == OFS_CFG;
  assign wr_eep  = host_wr && host_addr == OFS_EEP;
  assign wr_ist  = host_wr && host_addr == OFS_ISTAT;
  assign wr_ost  = host_wr && host_addr == OFS_OSTAT;
  assign wr_dout = host_wr && host_addr == OFS_DOUT;
  assign rd_din  = host_rd && host_addr == OFS_DIN;
  assign rd_isr  = host_rd && host_addr == OFS_ISR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      eep_q  <= '0;
      in_ie  <= 1'b0;
      out_ie <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      err_q <= err_in;
      if (wr_cfg) begin
        cfg_q      <= cfg_t'(host_wdata);
        cfg_q.rsvd <= 1'b0;
      end
      if (wr_eep) eep_q  <= host_wdata[4:1];
      if (wr_ist) in_ie  <= host_wdata[1];
      if (wr_ost) out_ie <= host_wdata[1];
    end
  end

  isa_win_sigid #(.SIG_W(SIG_WIDTH), .SIG_VAL(SIG_VALUE)) u_sigid (
    .clk(clk), .rst_n(rst_n), .restart(cfg_q.srst), .advance(rd_isr),
    .bit_o(sig_bit)
  );

  isa_win_link #(.DW(BYTE_W)) u_link (
    .clk(clk), .rst_n(rst_n),
    .in_valid(link_in_valid), .in_data(link_in_data), .in_ready(link_in_ready),
    .host_take(rd_din), .in_full(in_full), .in_byte(in_byte),
    .host_put(wr_dout), .host_byte(host_wdata),
    .out_valid(link_out_valid), .out_data(link_out_data),
    .out_ready(link_out_ready), .out_free(out_free)
  );

  assign err_int = err_q && cfg_q.perr_en;
  assign in_int  = in_full && in_ie;
  assign out_int = out_free && out_ie;
  assign irq_req = err_int || in_int || out_int;

  isa_win_irq #(.SEL_W(SEL_W), .PULSE_LEN(PULSE_LEN)) u_irq (
    .clk(clk), .rst_n(rst_n), .req(irq_req), .pulse_mode(cfg_q.pulse),
    .sel(cfg_q.line), .lines(irq_lines)
  );

  always_comb begin
    case (host_addr)
      OFS_CFG:   host_rdata = cfg_q;
      OFS_ISR:   host_rdata = {3'b000, err_q, sig_bit, in_int, out_int, err_int};
      OFS_EEP:   host_rdata = {3'b000, eep_q, ee_do};
      OFS_DIN:   host_rdata = in_byte;
      OFS_ISTAT: host_rdata = {6'b0, in_ie, in_full};
      OFS_OSTAT: host_rdata = {6'b0, out_ie, out_free};
      default:   host_rdata = 8'h00;
    endcase
  end

  assign host_wait = cfg_q.wait_en && (host_rd || host_wr);
  assign cpu_reset = cfg_q.srst;
  assign ee_di     = eep_q[0];
  assign ee_clk    = eep_q[1];
  assign ee_cs     = eep_q[2];
  assign ee_hold   = eep_q[3];
endmodule

// File: rtl/isa_host_window_chk.sv
module isa_host_window_chk #(
  parameter int PULSE_LEN = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] host_addr,
  input logic       host_rd,
  input logic       host_wr,
  input logic [6:0] irq_lines,
  input logic [7:0] cfg_bits,
  input logic       link_in_valid,
  input logic       link_in_ready,
  input logic       link_out_valid
);
  logic [7:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                hi_run <= '0;
    else if (cfg_bits[6] && (|irq_lines)) begin
      if (hi_run != 8'hFF)                     hi_run <= hi_run + 1'b1;
    end else                                   hi_run <= '0;
  end

  a_r3_single_line: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));

  a_r3_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_bits[5:3] == 3'b111) |-> (irq_lines == 7'b0));

  a_r5_pulse_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_bits[6] |-> (hi_run <= 8'(PULSE_LEN)));

  a_r10_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (link_in_valid && link_in_ready) |=> !link_in_ready);

  a_r10_read_frees: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 3'd4 && !link_in_ready) |=> link_in_ready);

  a_r11_write_offers: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 3'd5 && !link_out_valid) |=> link_out_valid);
endmodule

bind isa_host_window isa_host_window_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
  .host_wr(host_wr), .irq_lines(irq_lines), .cfg_bits(cfg_q),
  .link_in_valid(link_in_valid), .link_in_ready(link_in_ready),
  .link_out_valid(link_out_valid)
);

// File: tb/isa_host_window_bench.sv
module isa_host_window_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] host_addr = '0;
  logic       host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic       host_wait, cpu_reset;
  logic [6:0] irq_lines;
  logic       err_in = 1'b0, ee_do = 1'b0;
  logic       ee_di, ee_clk, ee_cs, ee_hold;
  logic       link_in_valid = 1'b0;
  logic [7:0] link_in_data = '0;
  logic       link_in_ready, link_out_valid;
  logic [7:0] link_out_data;
  logic       link_out_ready = 1'b0;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  isa_host_window u_isa_host_window (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic push_in(input logic [7:0] b);
    @(negedge clk);
    link_in_valid = 1'b1; link_in_data = b;
    @(negedge clk);
    link_in_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(3'd0, d); chk("R1 cfg reset", d, 8'h38);
    rd(3'd7, d); chk("R1 out status reset", d, 8'h01);
    rd(3'd6, d); chk("R1 in status reset", d, 8'h00);
    chk("R1 link ready/valid", {link_in_ready, link_out_valid}, 2'b10);
    chk("R1 no irq", irq_lines, 7'h0);
  endtask

  task automatic t_signature;
    logic [7:0] d;
    logic [15:0] got = '0;
    for (int i = 0; i < 16; i++) begin
      rd(3'd1, d);
      got[i] = d[3];
    end
    chk("R7 signature", got, 16'h0201);
    rd(3'd1, d); chk("R7 exhausted", d[3], 1'b0);
    rd(3'd1, d); chk("R7 stays zero", d[3], 1'b0);
  endtask

  task automatic t_softreset;
    logic [7:0] d;
    wr(3'd0, 8'hB8);
    chk("R2 cpu_reset high", cpu_reset, 1'b1);
    rd(3'd1, d); chk("R8 held at first bit", d[3], 1'b1);
    rd(3'd1, d); chk("R8 held again", d[3], 1'b1);
    wr(3'd0, 8'h38);
    chk("R2 cpu_reset low", cpu_reset, 1'b0);
    rd(3'd1, d); chk("R8 restart bit0", d[3], 1'b1);
    rd(3'd1, d); chk("R8 restart bit1", d[3], 1'b0);
  endtask

  task automatic t_config;
    logic [7:0] d;
    wr(3'd0, 8'h7F);
    rd(3'd0, d); chk("R2 cfg bit2 zero", d, 8'h7B);
    @(negedge clk);
    host_addr = 3'd0; host_rd = 1'b1;
    #1 chk("R2 wait during access", host_wait, 1'b1);
    @(negedge clk);
    host_rd = 1'b0;
    #1 chk("R2 wait idle", host_wait, 1'b0);
    wr(3'd0, 8'h38);
    @(negedge clk);
    host_addr = 3'd0; host_rd = 1'b1;
    #1 chk("R2 no wait when off", host_wait, 1'b0);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic t_routing;
    wr(3'd7, 8'h02);
    for (int c = 0; c < 8; c++) begin
      wr(3'd0, 8'(c << 3));
      @(negedge clk);
      chk($sformatf("R3 route code %0d", c), irq_lines,
          (c == 7) ? 7'h0 : 7'(1 << c));
    end
    wr(3'd7, 8'h00);
    @(negedge clk);
    chk("R4 out enable off drops line", irq_lines, 7'h0);
    wr(3'd0, 8'h38);
  endtask

  task automatic t_level;
    logic [7:0] d;
    wr(3'd0, 8'h28);
    wr(3'd6, 8'h02);
    chk("R4 idle low", irq_lines, 7'h0);
    push_in(8'h5A);
    chk("R4 level follows input", irq_lines, 7'h20);
    chk("R10 not ready when full", link_in_ready, 1'b0);
    rd(3'd6, d); chk("R10 in status", d, 8'h03);
    rd(3'd1, d); chk("R6 input bit", d & 8'hF7, 8'h04);
    rd(3'd4, d); chk("R10 byte", d, 8'h5A);
    chk("R4 level drops after read", irq_lines, 7'h0);
    chk("R10 ready again", link_in_ready, 1'b1);
    wr(3'd6, 8'h00);
  endtask

  task automatic t_pulse;
    logic [7:0] d;
    int hi = 0;
    wr(3'd0, 8'h68);
    wr(3'd6, 8'h02);
    push_in(8'hC3);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (irq_lines == 7'h20) hi++;
      else if (irq_lines != 7'h0) hi += 100;
    end
    chk("R5 pulse length", hi, 4);
    rd(3'd4, d); chk("R10 pulse byte", d, 8'hC3);
    wr(3'd6, 8'h00);
    wr(3'd0, 8'h38);
  endtask

  task automatic t_error;
    logic [7:0] d;
    wr(3'd0, 8'h38);
    @(negedge clk); err_in = 1'b1;
    @(negedge clk);
    rd(3'd1, d); chk("R6 raw error no enable", d & 8'hF7, 8'h10);
    wr(3'd0, 8'h09);
    rd(3'd1, d); chk("R6 enabled error", d & 8'hF7, 8'h11);
    chk("R4 error drives line", irq_lines, 7'h02);
    @(negedge clk); err_in = 1'b0;
    @(negedge clk);
    chk("R4 error cleared", irq_lines, 7'h0);
    wr(3'd0, 8'h38);
  endtask

  task automatic t_eeprom;
    logic [7:0] d;
    wr(3'd2, 8'hFF);
    chk("R9 pins all set", {ee_hold, ee_cs, ee_clk, ee_di}, 4'hF);
    ee_do = 1'b1;
    rd(3'd2, d); chk("R9 readback do=1", d, 8'h1F);
    ee_do = 1'b0;
    wr(3'd2, 8'h0A);
    chk("R9 pins pattern", {ee_hold, ee_cs, ee_clk, ee_di}, 4'h5);
    rd(3'd2, d); chk("R9 readback do=0", d, 8'h0A);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_output;
    logic [7:0] d;
    wr(3'd5, 8'hA5);
    chk("R11 offered", {link_out_valid, link_out_data}, {1'b1, 8'hA5});
    rd(3'd7, d); chk("R11 not ready", d, 8'h00);
    wr(3'd5, 8'h3C);
    chk("R11 write while busy ignored", link_out_data, 8'hA5);
    @(negedge clk); link_out_ready = 1'b1;
    @(negedge clk); link_out_ready = 1'b0;
    chk("R11 taken", link_out_valid, 1'b0);
    rd(3'd7, d); chk("R11 ready again", d, 8'h01);
  endtask

  task automatic t_unused;
    logic [7:0] d;
    wr(3'd3, 8'hFF);
    rd(3'd3, d); chk("R12 offset3 reads 0", d, 8'h00);
    rd(3'd5, d); chk("R12 offset5 reads 0", d, 8'h00);
    rd(3'd0, d); chk("R12 cfg untouched", d, 8'h38);
    rd(3'd2, d); chk("R12 eeprom untouched", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_signature;
    t_softreset;
    t_config;
    t_routing;
    t_level;
    t_pulse;
    t_error;
    t_eeprom;
    t_output;
    t_unused;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule